// File: doc/BRIEF.md
# Pipeline Memory Access Tap

This block sits beside a simple in-order CPU pipeline and watches it. The core has an execute, a memory and a writeback stage. The tap produces one record for every load or store the core really carries out. A record gives four things: the program counter of the instruction that made the access, whether it was a load or a store, the data address widened to the full physical width, and a one-cycle valid strobe. A downstream checker, such as a region-permission unit, consumes these records.

The tap only reads signals the core already drives: the execute-stage PC, valid and control bits, the data-cache request strobe and address, the pipeline stall and the memory-stage flush. Nothing flows back into the core. The tap aligns the PC and the access type with the address by using the execute control bits. It carries them alongside the instruction through a shadow memory stage that stalls and flushes in step with the core's own memory stage.

Top module: `mem_access_tap`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rec_en` is 0, and no record appears unless an access has been taken since.
- R2: An execute-stage access is taken at a rising edge when `pipe_stall` is low. It is not flushed at the following edge, which also has `pipe_stall` low. A load taken this way gives `rec_en`=1 after that second edge, with `rec_store`=0.
- R3: A store taken and not flushed in the same way gives `rec_en`=1 with `rec_store`=1. The encoding is 0 for load and 1 for store.
- R4: `rec_pc` equals the `ex_pc` value that was present when the access was taken.
- R5: `rec_paddr` is `dc_addr` sign-extended from bit VA_W-1 to PA_W bits. With the default widths of 32 and 40, the upper 8 bits copy bit 31.
- R6: An access exists only when `ex_valid`, `dc_req` and at least one of `ex_is_load`/`ex_is_store` are all 1. In any other case no record is produced. The store bit alone selects the type.
- R7: While `pipe_stall` is high, no access is taken and no record is emitted. An access that is pending or held emits exactly one record after the first edge at which the stall is low.
- R8: `mem_kill` high at an edge discards the access held in the shadow memory stage, even during a stall, and also discards any execute access at that edge. No record results from either.
- R9: `rec_en` is high for exactly one cycle per access. Accesses on consecutive cycles give records on consecutive cycles, in order, each with its own fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_pc | input | PC_W | Execute-stage program counter |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_is_load | input | 1 | Execute control: instruction is a load |
| ex_is_store | input | 1 | Execute control: instruction is a store |
| dc_req | input | 1 | Data-cache request strobe from execute |
| dc_addr | input | VA_W | Data-cache request address |
| pipe_stall | input | 1 | Pipeline hold; no stage advances |
| mem_kill | input | 1 | Flush of the memory stage and younger |
| rec_pc | output | PC_W | PC of the issuing instruction |
| rec_store | output | 1 | Access type, 0 load, 1 store |
| rec_paddr | output | PA_W | Extended physical data address |
| rec_en | output | 1 | One-cycle record valid strobe |

## Verification
Each record is due two rising edges after its access is presented. The first edge takes the access into the shadow stage and the second loads the output registers. A stall adds one cycle for each edge at which it holds. The bench drives inputs on falling edges and samples on the falling edge that follows the second edge. It also samples on the falling edge before it, to confirm that the strobe has not risen early, and on the one after, to confirm that it has fallen again. For stall and flush cases, the bench checks the strobe at every falling edge while the condition holds and then once more at the expected release.

// File: rtl/tap_pkg.sv
package tap_pkg;

  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_kind_e;

  // An execute-stage instruction is a live memory access
  function automatic logic is_mem_access(input logic valid, input logic ld,
                                         input logic st, input logic req);
    return valid & req & (ld | st);
  endfunction

  // The type follows the store control bit alone
  function automatic acc_kind_e kind_of(input logic st);
    return st ? ACC_STORE : ACC_LOAD;
  endfunction

endpackage

// File: rtl/tap_addr_ext.sv
module tap_addr_ext #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 40,
  parameter bit SIGN_EXT = 1'b1
) (
  input  logic [VA_W-1:0] va,
  output logic [PA_W-1:0] pa
);
  localparam int PAD_W = PA_W - VA_W;

  generate
    if (PAD_W <= 0) begin : g_trunc
      assign pa = va[PA_W-1:0];
    end else if (SIGN_EXT) begin : g_sign
      assign pa = {{PAD_W{va[VA_W-1]}}, va};
    end else begin : g_zero
      assign pa = {{PAD_W{1'b0}}, va};
    end
  endgenerate
endmodule

// File: rtl/tap_capture.sv
module tap_capture #(
  parameter int PC_W = 32,
  parameter int PA_W = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic                hold,
  input  logic                kill,
  input  logic [PC_W-1:0]     pc_in,
  input  tap_pkg::acc_kind_e  kind_in,
  input  logic [PA_W-1:0]     pa_in,
  output logic                full,
  output logic [PC_W-1:0]     pc_q,
  output tap_pkg::acc_kind_e  kind_q,
  output logic [PA_W-1:0]     pa_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full   <= 1'b0;
      pc_q   <= '0;
      kind_q <= tap_pkg::ACC_LOAD;
      pa_q   <= '0;
    end else if (kill) begin
      full <= 1'b0;
    end else if (!hold) begin
      full <= take;
      if (take) begin
        pc_q   <= pc_in;
        kind_q <= kind_in;
        pa_q   <= pa_in;
      end
    end
  end
endmodule

// File: rtl/tap_emit.sv
module tap_emit #(
  parameter int PC_W = 32,
  parameter int PA_W = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic [PC_W-1:0]     pc_in,
  input  tap_pkg::acc_kind_e  kind_in,
  input  logic [PA_W-1:0]     pa_in,
  output logic                en_q,
  output logic [PC_W-1:0]     pc_q,
  output logic                store_q,
  output logic [PA_W-1:0]     pa_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      pc_q    <= '0;
      store_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      en_q <= fire;
      if (fire) begin
        pc_q    <= pc_in;
        store_q <= (kind_in == tap_pkg::ACC_STORE);
        pa_q    <= pa_in;
      end
    end
  end
endmodule

// File: rtl/mem_access_tap.sv
module mem_access_tap #(
  parameter int PC_W     = 32,
  parameter int VA_W     = 32,
  parameter int PA_W     = 40,
  parameter bit SIGN_EXT = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] ex_pc,
  input  logic            ex_valid,
  input  logic            ex_is_load,
  input  logic            ex_is_store,
  input  logic            dc_req,
  input  logic [VA_W-1:0] dc_addr,
  input  logic            pipe_stall,
  input  logic            mem_kill,
  output logic [PC_W-1:0] rec_pc,
  output logic            rec_store,
  output logic [PA_W-1:0] rec_paddr,
  output logic            rec_en
);
  import tap_pkg::*;

  // Named internal events for the checker
  logic               acc_seen;
  logic               stage_full;
  logic               emit_fire;
  logic [PA_W-1:0]    ext_pa;
  acc_kind_e          ex_kind;
  logic [PC_W-1:0]    st_pc;
  acc_kind_e          st_kind;
  logic [PA_W-1:0]    st_pa;

  assign acc_seen  = is_mem_access(ex_valid, ex_is_load, ex_is_store, dc_req);
  assign ex_kind   = kind_of(ex_is_store);
  assign emit_fire = stage_full & ~pipe_stall & ~mem_kill;

  tap_addr_ext #(.VA_W(VA_W), .PA_W(PA_W), .SIGN_EXT(SIGN_EXT)) u_ext (
    .va (dc_addr),
    .pa (ext_pa)
  );

  tap_capture #(.PC_W(PC_W), .PA_W(PA_W)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .take    (acc_seen),
    .hold    (pipe_stall),
    .kill    (mem_kill),
    .pc_in   (ex_pc),
    .kind_in (ex_kind),
    .pa_in   (ext_pa),
    .full    (stage_full),
    .pc_q    (st_pc),
    .kind_q  (st_kind),
    .pa_q    (st_pa)
  );

  tap_emit #(.PC_W(PC_W), .PA_W(PA_W)) u_emit (
    .clk     (clk),
    .rst     (rst),
    .fire    (emit_fire),
    .pc_in   (st_pc),
    .kind_in (st_kind),
    .pa_in   (st_pa),
    .en_q    (rec_en),
    .pc_q    (rec_pc),
    .store_q (rec_store),
    .pa_q    (rec_paddr)
  );
endmodule

// File: rtl/tap_checker.sv
module tap_checker #(
  parameter int PC_W     = 32,
  parameter int VA_W     = 32,
  parameter int PA_W     = 40
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] ex_pc,
  input logic            ex_is_store,
  input logic [VA_W-1:0] dc_addr,
  input logic            pipe_stall,
  input logic            mem_kill,
  input logic            acc_seen,
  input logic            stage_full,
  input logic [PA_W-1:0] ext_pa,
  input logic [PC_W-1:0] rec_pc,
  input logic            rec_store,
  input logic [PA_W-1:0] rec_paddr,
  input logic            rec_en
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !rec_en);

  // R2 R3 R4: type and pc follow the access two edges later
  p_record_fields_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_seen && !pipe_stall && !mem_kill) ##1 (!pipe_stall && !mem_kill)
    |=> rec_en && rec_store == $past(ex_is_store, 2) && rec_pc == $past(ex_pc, 2));

  p_addr_ext_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_seen && !pipe_stall && !mem_kill) ##1 (!pipe_stall && !mem_kill)
    |=> rec_paddr == $past(ext_pa, 2) && rec_paddr[VA_W-1:0] == $past(dc_addr, 2));

  p_no_access_r6: assert property (@(posedge clk) disable iff (rst)
    (!acc_seen && !pipe_stall) |=> !stage_full);

  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    pipe_stall |=> !rec_en);

  p_kill_drop_r8: assert property (@(posedge clk) disable iff (rst)
    mem_kill |=> !rec_en && !stage_full);

  p_no_phantom_r9: assert property (@(posedge clk) disable iff (rst)
    !stage_full |=> !rec_en);
endmodule

bind mem_access_tap tap_checker #(.PC_W(PC_W), .VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ex_pc       (ex_pc),
  .ex_is_store (ex_is_store),
  .dc_addr     (dc_addr),
  .pipe_stall  (pipe_stall),
  .mem_kill    (mem_kill),
  .acc_seen    (acc_seen),
  .stage_full  (stage_full),
  .ext_pa      (ext_pa),
  .rec_pc      (rec_pc),
  .rec_store   (rec_store),
  .rec_paddr   (rec_paddr),
  .rec_en      (rec_en)
);

// File: tb/tb_mem_access_tap.sv
module tb_mem_access_tap;
  localparam int PC_W = 32;
  localparam int VA_W = 32;
  localparam int PA_W = 40;
  localparam int NV   = 7;

  logic            clk = 1'b0;
  logic            rst;
  logic [PC_W-1:0] ex_pc;
  logic            ex_valid, ex_is_load, ex_is_store, dc_req;
  logic [VA_W-1:0] dc_addr;
  logic            pipe_stall, mem_kill;
  logic [PC_W-1:0] rec_pc;
  logic            rec_store;
  logic [PA_W-1:0] rec_paddr;
  logic            rec_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mem_access_tap #(.PC_W(PC_W), .VA_W(VA_W), .PA_W(PA_W)) dut (
    .clk(clk), .rst(rst), .ex_pc(ex_pc), .ex_valid(ex_valid),
    .ex_is_load(ex_is_load), .ex_is_store(ex_is_store), .dc_req(dc_req),
    .dc_addr(dc_addr), .pipe_stall(pipe_stall), .mem_kill(mem_kill),
    .rec_pc(rec_pc), .rec_store(rec_store), .rec_paddr(rec_paddr), .rec_en(rec_en)
  );

  // Vector table: valid, load, store, req, pc, address
  localparam logic [3:0]  V_CTL [NV] = '{4'b1101, 4'b1011, 4'b0101, 4'b1001,
                                         4'b1100, 4'b1011, 4'b1101};
  localparam logic [31:0] V_PC  [NV] = '{32'h100, 32'h104, 32'h108, 32'h10c,
                                         32'h110, 32'h114, 32'h118};
  localparam logic [31:0] V_AD  [NV] = '{32'h0000_1000, 32'h8000_0004, 32'h1234_0000,
                                         32'h2222_2222, 32'h3333_3333, 32'hffff_fffc,
                                         32'h7fff_ffff};

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference extension written independently: signed widening
  function automatic logic [PA_W-1:0] ref_pa(input logic [VA_W-1:0] a);
    logic signed [PA_W-1:0] w;
    w = PA_W'($signed(a));
    return w;
  endfunction

  task automatic idle();
    ex_valid = 0; ex_is_load = 0; ex_is_store = 0; dc_req = 0;
    ex_pc = '0; dc_addr = '0;
  endtask

  task automatic drive(input logic v, input logic l, input logic s, input logic r,
                       input logic [31:0] pc, input logic [31:0] ad);
    ex_valid = v; ex_is_load = l; ex_is_store = s; dc_req = r;
    ex_pc = pc; dc_addr = ad;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; pipe_stall = 0; mem_kill = 0; idle();
    repeat (3) @(negedge clk);
    chk("R1 en in reset", rec_en, 0);
    rst = 0;
    @(negedge clk); chk("R1 en after reset", rec_en, 0);
    @(negedge clk); chk("R1 no record idle", rec_en, 0);

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic e;
      drive(V_CTL[i][3], V_CTL[i][2], V_CTL[i][1], V_CTL[i][0], V_PC[i], V_AD[i]);
      e = V_CTL[i][3] & V_CTL[i][0] & (V_CTL[i][2] | V_CTL[i][1]);
      @(negedge clk); idle();
      chk("R2 no early strobe", rec_en, 0);
      @(negedge clk);
      chk("R6 R2 strobe", rec_en, e);
      if (e) begin
        chk("R3 type", rec_store, V_CTL[i][1]);
        chk("R4 pc", rec_pc, V_PC[i]);
        chk("R5 paddr", rec_paddr, ref_pa(V_AD[i]));
      end
      @(negedge clk); chk("R9 single pulse", rec_en, 0);
    end

    // R7: stall before capture, EX holds its access
    drive(1, 1, 0, 1, 32'h200, 32'h40);
    pipe_stall = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); chk("R7 quiet in stall", rec_en, 0);
    end
    pipe_stall = 0;
    @(negedge clk); idle(); chk("R7 not yet", rec_en, 0);
    @(negedge clk); chk("R7 released record", rec_en, 1);
    chk("R7 pc", rec_pc, 32'h200);
    @(negedge clk); chk("R7 exactly once", rec_en, 0);

    // R7: stall while held in shadow stage
    drive(1, 0, 1, 1, 32'h204, 32'h44);
    @(negedge clk); idle(); pipe_stall = 1;
    @(negedge clk); chk("R7 held quiet", rec_en, 0);
    @(negedge clk); chk("R7 held quiet 2", rec_en, 0);
    pipe_stall = 0;
    @(negedge clk); chk("R7 held emits", rec_en, 1);
    chk("R7 held type", rec_store, 1);
    @(negedge clk); chk("R7 held once", rec_en, 0);

    // R8: flush in memory stage
    drive(1, 1, 0, 1, 32'h300, 32'h50);
    @(negedge clk); idle(); mem_kill = 1;
    @(negedge clk); mem_kill = 0; chk("R8 killed", rec_en, 0);
    @(negedge clk); chk("R8 stays dropped", rec_en, 0);

    // R8: flush while stalled
    drive(1, 0, 1, 1, 32'h304, 32'h54);
    @(negedge clk); idle(); pipe_stall = 1;
    @(negedge clk); mem_kill = 1;
    @(negedge clk); mem_kill = 0; pipe_stall = 0;
    chk("R8 killed in stall", rec_en, 0);
    @(negedge clk); chk("R8 no late record", rec_en, 0);

    // R9: back-to-back accesses
    drive(1, 1, 0, 1, 32'h400, 32'h60);
    @(negedge clk); drive(1, 0, 1, 1, 32'h404, 32'h8000_0064);
    @(negedge clk); idle();
    chk("R9 first", rec_en, 1); chk("R9 first pc", rec_pc, 32'h400);
    chk("R9 first type", rec_store, 0);
    @(negedge clk);
    chk("R9 second", rec_en, 1); chk("R9 second pc", rec_pc, 32'h404);
    chk("R9 second type", rec_store, 1);
    chk("R9 second paddr", rec_paddr, 40'hff_8000_0064);
    @(negedge clk); chk("R9 ends", rec_en, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule